// File: doc/BRIEF.md
# Microcontroller Standby Mode Controller

This block supervises the two low-power states of a small microcontroller core. Software writes a processor clock control word; one bit asks for a light sleep (HALT), in which only the CPU clock is gated, and another asks for a deep sleep (STOP), in which the main oscillator is also switched off. From its state and from each peripheral's clock-source selection, the block drives clock enables for the CPU, the main oscillator, the interval/watchdog timer, the serial interface, the timer/event counter and the clock timer.

An interrupt request whose enable flag is set brings the core back from either state. In STOP, one or more lines, selected by a parameter and by default line 0, cannot wake the core. After a STOP wake the main oscillator is turned on at once. The CPU clock is held off for a fixed settling count before it returns. When the CPU clock is restored the block raises a one-cycle wake pulse and clears its standby bits. A synchronous reset returns everything to normal operation from any state. Register and memory contents belong to the surrounding core and are not touched.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: In run state, a write with bit 2 set and bit 3 clear enters HALT. The next cycle shows mode_bits = 01 (bit 0 = HALT, bit 1 = STOP) and cpu_clk_en = 0. All other enables stay 1, whatever the clock sources and the core clock.
- R2: In run state, a write with bit 3 set while core_on_sub = 0 enters STOP. The next cycle shows mode_bits = 10 and cpu_clk_en, main_osc_en and wdt_clk_en all 0.
- R3: A write with bit 3 set while core_on_sub = 1 does not enter STOP. If bit 2 is also set, HALT is entered; otherwise the state is unchanged. On the main clock, with both bits set, STOP wins.
- R4: In STOP, sio_clk_en follows sio_ext_clk, tec_clk_en follows tec_pin_clk and ctm_clk_en follows ctm_sub_clk.
- R5: In HALT, an irq line with both request and enable at 1 at a clock edge gives mode_bits = 00, cpu_clk_en = 1 and wake = 1 after that edge.
- R6: An irq request whose enable bit is 0 never releases HALT or STOP.
- R7: In STOP, the lines marked in STOP_MASKED (default: line 0) do not release the core; other enabled lines do. In HALT, every enabled line releases the core.
- R8: On release from STOP, main_osc_en is 1 after the release edge. cpu_clk_en stays 0 and mode_bits stays 10 for STAB_CYC cycles, and then cpu_clk_en returns to 1.
- R9: Synchronous reset, from any state, gives mode_bits = 00, all six enables 1 and wake = 0 after the edge.
- R10: A write with bits 2 and 3 both clear (clock-select field only) leaves all enables at 1 and mode_bits at 00.
- R11: wake lasts exactly one cycle and fires only together with mode_bits = 00 and cpu_clk_en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the clock control word |
| ctl_wdata | input | 4 | Control word: bit 3 STOP, bit 2 HALT, bits 1:0 clock select (not used here) |
| core_on_sub | input | 1 | 1 when the core currently runs from the subsystem clock |
| sio_ext_clk | input | 1 | Serial interface uses an external shift clock |
| tec_pin_clk | input | 1 | Timer/event counter counts the external count pin |
| ctm_sub_clk | input | 1 | Clock timer counts the subsystem clock |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Interrupt enable flags |
| cpu_clk_en | output | 1 | CPU clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| wdt_clk_en | output | 1 | Interval/watchdog timer clock enable |
| sio_clk_en | output | 1 | Serial interface clock enable |
| tec_clk_en | output | 1 | Timer/event counter clock enable |
| ctm_clk_en | output | 1 | Clock timer clock enable |
| wake | output | 1 | One-cycle pulse when the CPU clock resumes |
| mode_bits | output | 2 | Standby bits: bit 0 HALT, bit 1 STOP |

## Verification
The embedded assertions check on every cycle that the CPU clock is gated whenever a standby bit is set. They also check that the oscillator is off only in STOP and that the watchdog clock never runs without the oscillator. Further assertions cover the wake pulse (its length, and that it comes only with normal operation), the HALT entry rule, the refusal of STOP on the subsystem clock and the bound on the settling counter. Other behaviours only the bench scenarios can show: the peripheral enables for each source selection in STOP, that the masked line cannot wake from STOP but can wake from HALT, the exact settling length after a STOP wake, and reset from inside each standby state.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int HALT_BIT = 2;
    localparam int STOP_BIT = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STOP = 2'd2,
        ST_WARM = 2'd3
    } stby_state_e;

    typedef struct packed {
        logic cpu;
        logic osc;
        logic wdt;
        logic sio;
        logic tec;
        logic ctm;
    } clk_en_t;

    typedef struct packed {
        logic sio_ext;
        logic tec_pin;
        logic ctm_sub;
    } periph_src_t;

    // Clock enables for one state, given the peripheral source selections
    function automatic clk_en_t enables_for(stby_state_e s, periph_src_t src);
        clk_en_t e;
        e = '{cpu: 1'b1, osc: 1'b1, wdt: 1'b1, sio: 1'b1, tec: 1'b1, ctm: 1'b1};
        case (s)
            ST_HALT, ST_WARM: e.cpu = 1'b0;
            ST_STOP: begin
                e.cpu = 1'b0;
                e.osc = 1'b0;
                e.wdt = 1'b0;
                e.sio = src.sio_ext;
                e.tec = src.tec_pin;
                e.ctm = src.ctm_sub;
            end
            default: ;
        endcase
        return e;
    endfunction

    function automatic logic [1:0] mode_of(stby_state_e s);
        case (s)
            ST_HALT:          return 2'b01;
            ST_STOP, ST_WARM: return 2'b10;
            default:          return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/stby_wake_detect.sv
module stby_wake_detect
    import stby_pkg::*;
#(
    parameter int              NUM_IRQ     = 8,
    parameter logic [NUM_IRQ-1:0] STOP_MASKED = 1
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               rel_halt,
    output logic               rel_stop
);
    logic [NUM_IRQ-1:0] live_any;
    logic [NUM_IRQ-1:0] live_deep;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign live_any[i] = irq_req[i] & irq_en[i];
        if (STOP_MASKED[i]) begin : g_masked
            assign live_deep[i] = 1'b0;
        end else begin : g_open
            assign live_deep[i] = live_any[i];
        end
    end

    assign rel_halt = |live_any;
    assign rel_stop = |live_deep;

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
#(
    parameter int STAB_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic        req_halt,
    input  logic        req_stop,
    input  logic        core_on_sub,
    input  logic        rel_halt,
    input  logic        rel_stop,
    output stby_state_e state,
    output logic        wake
);
    localparam int CW = (STAB_CYC < 2) ? 1 : $clog2(STAB_CYC);
    localparam logic [CW-1:0] LOAD = CW'(STAB_CYC - 1);

    stby_state_e   nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          go_wake;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        go_wake = 1'b0;
        case (state)
            ST_RUN: begin
                if (ctl_we) begin
                    if (req_stop && !core_on_sub) nxt = ST_STOP;
                    else if (req_halt)            nxt = ST_HALT;
                end
            end
            ST_HALT: begin
                if (rel_halt) begin
                    nxt     = ST_RUN;
                    go_wake = 1'b1;
                end
            end
            ST_STOP: begin
                if (rel_stop) begin
                    nxt     = ST_WARM;
                    cnt_nxt = LOAD;
                end
            end
            ST_WARM: begin
                if (cnt == '0) begin
                    nxt     = ST_RUN;
                    go_wake = 1'b1;
                end else begin
                    cnt_nxt = cnt - CW'(1);
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
            wake  <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            wake  <= go_wake;
        end
    end

    // R1: a HALT-only request in run state lands in HALT
    assert_halt_entry_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && ctl_we && req_halt && !req_stop) |=> (state == ST_HALT));

    // R3: STOP alone on the subsystem clock is refused
    assert_stop_refused_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && ctl_we && req_stop && !req_halt && core_on_sub) |=> (state == ST_RUN));

    // R6: HALT holds while no enabled request is present
    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !rel_halt) |=> (state == ST_HALT));

    // R8: settling counter stays inside its window
    assert_warm_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WARM) |-> (cnt <= LOAD));

endmodule

// File: rtl/stby_clk_gate.sv
module stby_clk_gate
    import stby_pkg::*;
(
    input  stby_state_e state,
    input  periph_src_t src,
    output clk_en_t     en,
    output logic [1:0]  mode
);
    always_comb begin
        en   = enables_for(state, src);
        mode = mode_of(state);
    end
endmodule

// File: rtl/pwr_standby_ctrl.sv
module pwr_standby_ctrl
    import stby_pkg::*;
#(
    parameter int                 NUM_IRQ     = 8,
    parameter logic [NUM_IRQ-1:0] STOP_MASKED = 1,
    parameter int                 STAB_CYC    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_we,
    input  logic [3:0]         ctl_wdata,
    input  logic               core_on_sub,
    input  logic               sio_ext_clk,
    input  logic               tec_pin_clk,
    input  logic               ctm_sub_clk,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               cpu_clk_en,
    output logic               main_osc_en,
    output logic               wdt_clk_en,
    output logic               sio_clk_en,
    output logic               tec_clk_en,
    output logic               ctm_clk_en,
    output logic               wake,
    output logic [1:0]         mode_bits
);
    stby_state_e state;
    logic        rel_halt, rel_stop;
    clk_en_t     en;
    periph_src_t src;
    logic        unused_sel_bits;

    // Clock-select field is handled by the clock generator, not here
    assign unused_sel_bits = ^ctl_wdata[1:0];

    assign src = '{sio_ext: sio_ext_clk, tec_pin: tec_pin_clk, ctm_sub: ctm_sub_clk};

    stby_wake_detect #(
        .NUM_IRQ     (NUM_IRQ),
        .STOP_MASKED (STOP_MASKED)
    ) u_wake (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .rel_halt (rel_halt),
        .rel_stop (rel_stop)
    );

    stby_fsm #(
        .STAB_CYC (STAB_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctl_we      (ctl_we),
        .req_halt    (ctl_wdata[HALT_BIT]),
        .req_stop    (ctl_wdata[STOP_BIT]),
        .core_on_sub (core_on_sub),
        .rel_halt    (rel_halt),
        .rel_stop    (rel_stop),
        .state       (state),
        .wake        (wake)
    );

    stby_clk_gate u_gate (
        .state (state),
        .src   (src),
        .en    (en),
        .mode  (mode_bits)
    );

    assign cpu_clk_en  = en.cpu;
    assign main_osc_en = en.osc;
    assign wdt_clk_en  = en.wdt;
    assign sio_clk_en  = en.sio;
    assign tec_clk_en  = en.tec;
    assign ctm_clk_en  = en.ctm;

    // R1: CPU clock is off whenever a standby bit is set
    assert_cpu_gated_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_bits != 2'b00) |-> !cpu_clk_en);

    // R2: oscillator is off only in STOP
    assert_osc_stop_only_R2: assert property (@(posedge clk) disable iff (rst)
        !main_osc_en |-> (mode_bits == 2'b10));

    // R2: watchdog clock never runs without the oscillator
    assert_wdt_needs_osc_R2: assert property (@(posedge clk) disable iff (rst)
        wdt_clk_en |-> main_osc_en);

    // R11: wake comes with normal operation and lasts one cycle
    assert_wake_clean_R11: assert property (@(posedge clk) disable iff (rst)
        wake |-> (mode_bits == 2'b00 && cpu_clk_en));

    assert_wake_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    // R9: reset restores all enables
    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (cpu_clk_en && main_osc_en && wdt_clk_en && sio_clk_en &&
                 tec_clk_en && ctm_clk_en && !wake && mode_bits == 2'b00));

endmodule

// File: tb/sim_pwr_standby_ctrl.sv
module sim_pwr_standby_ctrl;
    localparam int NI   = 8;
    localparam int STAB = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_we = 1'b0;
    logic [3:0]    ctl_wdata = '0;
    logic          core_on_sub = 1'b0;
    logic          sio_ext_clk = 1'b0, tec_pin_clk = 1'b0, ctm_sub_clk = 1'b0;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic          cpu_clk_en, main_osc_en, wdt_clk_en, sio_clk_en, tec_clk_en, ctm_clk_en;
    logic          wake;
    logic [1:0]    mode_bits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    pwr_standby_ctrl #(.NUM_IRQ(NI), .STOP_MASKED(8'h01), .STAB_CYC(STAB)) u0 (
        .clk, .rst, .ctl_we, .ctl_wdata, .core_on_sub,
        .sio_ext_clk, .tec_pin_clk, .ctm_sub_clk, .irq_req, .irq_en,
        .cpu_clk_en, .main_osc_en, .wdt_clk_en, .sio_clk_en, .tec_clk_en,
        .ctm_clk_en, .wake, .mode_bits
    );

    // Vector: [15:12] write data, [11] core_on_sub, [10:8] sio/tec/ctm sources,
    //         [7:6] expected mode_bits, [5:0] expected cpu,osc,wdt,sio,tec,ctm
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        16'h405F,  // R1 HALT on main
        16'h485F,  // R1 R3 HALT on subsystem clock
        16'h475F,  // R1 HALT, all sources external
        16'h8080,  // R2 STOP, no external sources
        16'h8787,  // R4 STOP, all external sources
        16'h8484,  // R4 STOP, serial external only
        16'h8282,  // R4 STOP, count pin only
        16'h8181,  // R4 STOP, clock timer on subsystem only
        16'h883F,  // R3 STOP refused on subsystem clock
        16'hC080,  // R3 both bits on main: STOP
        16'hC85F,  // R3 both bits on subsystem: HALT
        16'h303F   // R10 clock-select write only
    };

    function automatic logic [5:0] en_now();
        return {cpu_clk_en, main_osc_en, wdt_clk_en, sio_clk_en, tec_clk_en, ctm_clk_en};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        tick();
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        tick();
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic pulse_irq(input int line);
        @(negedge clk); irq_req[line] = 1'b1;
        tick();
        irq_req = '0;
    endtask

    initial begin
        // R9: reset state
        tick(); tick();
        @(negedge clk); rst = 1'b0;
        chk("R9 reset enables", int'(en_now()), 'h3F);
        chk("R9 reset mode", int'(mode_bits), 0);
        chk("R9 reset wake", int'(wake), 0);

        // Vector table: R1 R2 R3 R4 R10
        for (int v = 0; v < NV; v++) begin
            do_reset();
            @(negedge clk);
            core_on_sub = VEC[v][11];
            {sio_ext_clk, tec_pin_clk, ctm_sub_clk} = VEC[v][10:8];
            do_write(VEC[v][15:12]);
            chk($sformatf("R1/R2/R3/R4/R10 vec%0d mode", v), int'(mode_bits), int'(VEC[v][7:6]));
            chk($sformatf("R1/R2/R3/R4/R10 vec%0d enables", v), int'(en_now()), int'(VEC[v][5:0]));
        end
        @(negedge clk);
        core_on_sub = 1'b0;
        {sio_ext_clk, tec_pin_clk, ctm_sub_clk} = 3'b000;

        // R6: request without enable does not release HALT
        do_reset();
        irq_en = '0;
        do_write(4'b0100);
        pulse_irq(3);
        tick(); tick();
        chk("R6 HALT held, mode", int'(mode_bits), 1);
        chk("R6 HALT held, cpu", int'(cpu_clk_en), 0);

        // R5 R7: enabled line 0 releases HALT
        @(negedge clk); irq_en = 8'h01;
        pulse_irq(0);
        chk("R5 HALT release mode", int'(mode_bits), 0);
        chk("R5 HALT release cpu", int'(cpu_clk_en), 1);
        chk("R11 wake on HALT release", int'(wake), 1);
        tick();
        chk("R11 wake one cycle", int'(wake), 0);

        // R7 R8: STOP, line 0 masked, line 1 releases after settling
        do_reset();
        @(negedge clk); irq_en = 8'h03;
        do_write(4'b1000);
        pulse_irq(0);
        tick();
        chk("R7 masked line keeps STOP", int'(mode_bits), 2);
        chk("R7 masked line osc off", int'(main_osc_en), 0);
        @(negedge clk); irq_en = 8'h00;
        pulse_irq(1);
        chk("R6 disabled line keeps STOP", int'(main_osc_en), 0);
        @(negedge clk); irq_en = 8'h02;
        pulse_irq(1);
        chk("R8 osc back after release", int'(main_osc_en), 1);
        chk("R8 cpu still off", int'(cpu_clk_en), 0);
        chk("R8 mode still STOP", int'(mode_bits), 2);
        for (int k = 0; k < STAB - 1; k++) tick();
        chk("R8 cpu off at last settle cycle", int'(cpu_clk_en), 0);
        chk("R8 wake not early", int'(wake), 0);
        tick();
        chk("R8 cpu back after settle", int'(cpu_clk_en), 1);
        chk("R11 wake at STOP exit", int'(wake), 1);
        chk("R11 mode clear at wake", int'(mode_bits), 0);
        tick();
        chk("R11 wake one cycle after STOP", int'(wake), 0);

        // R9: reset from inside HALT and STOP
        do_reset();
        do_write(4'b0100);
        do_reset();
        chk("R9 reset from HALT", int'(en_now()), 'h3F);
        do_write(4'b1000);
        do_reset();
        chk("R9 reset from STOP enables", int'(en_now()), 'h3F);
        chk("R9 reset from STOP mode", int'(mode_bits), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule